// File: doc/BRIEF.md
# Receive DMA Frame Buffer Manager

This block places received network frames into a circular region of host memory through a plain write port, one 16-bit halfword per write. A frame is announced by a start pulse that carries its byte length and receive status. If the frame fits, the block writes the status halfword first and the length halfword next. The payload halfwords follow as they arrive. The next frame then begins at the following 4-byte-aligned offset, and the padding bytes in between are left untouched. A frame that does not fit is discarded whole and counted as missed, so software never sees part of a frame.

Software hands buffer space back through a frame-count register that is read twice per pass. The first read reports the completed frames not yet reported and reserves them. The second read hands their bytes back to the free pool and moves the start-of-frame pointer past them. The block also presents the following:
- a byte-occupancy count;
- a start-of-frame pointer to the oldest unprocessed frame;
- an event register whose bit 7 announces newly stored frames and is cleared by reading that register.

Top module: `rxdma_frame_buf`

## Requirements
- R1: An accepted frame of L bytes produces, in order, a write of the status halfword at the frame start offset S, a write of L at S+2, and ceil(L/2) payload writes at S+4, S+6, … carrying the rx_data words in arrival order. Only cycles with rx_dvalid high in the payload phase produce writes.
- R2: The next frame starts at S + 4·ceil((L+4)/4), so every frame start offset is a multiple of 4.
- R3: Every write address is BASE_ADDR plus an offset taken modulo 2^BUF_AW. Offsets wrap to the buffer start past the buffer end.
- R4: A read of the frame count in the reserve phase returns the number of frames completed since the previous reserve read, and marks exactly those frames as reserved.
- R5: A read in the release phase returns the number of reserved frames. It lowers byte_cnt by their footprint and advances sof_ptr by the same amount, modulo the buffer size.
- R6: Count reads alternate strictly between the reserve and release phases, starting in the reserve phase after reset.
- R7: A frame whose footprint 4·ceil((L+4)/4) exceeds the free bytes (2^BUF_AW − byte_cnt) causes no write at all, increments miss_cnt by one, and leaves the count and occupancy unchanged. A frame that exactly fills the free space is accepted.
- R8: buf_evt bit 7 is set when a frame completes and cleared by an evt_rd pulse. A completion in the same cycle as the read wins. All other buf_evt bits read 0.
- R9: After reset, sof_ptr equals BASE_ADDR, and byte_cnt, cnt_val, miss_cnt and buf_evt are all 0.
- R10: Frames completed after a reserve read are not included in the following release read's count. The next reserve read reports them.
- R11: Stored bytes never exceed 2^BUF_AW, so reserved and unreleased data are never overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Frame announcement pulse, taken while idle |
| rx_len | input | LEN_W | Frame byte length, valid with rx_sof |
| rx_stat | input | 16 | Receive status, valid with rx_sof |
| rx_dvalid | input | 1 | Payload halfword valid |
| rx_data | input | 16 | Payload halfword |
| dma_we | output | 1 | Memory write strobe |
| dma_addr | output | ADDR_W | Byte address of the write |
| dma_wdata | output | 16 | Write data |
| cnt_rd | input | 1 | Frame-count read strobe |
| cnt_val | output | CNT_W | Frame-count read value for the current phase |
| evt_rd | input | 1 | Event register read strobe, clears bit 7 |
| buf_evt | output | 16 | Event register, bit 7 = frames stored |
| sof_ptr | output | ADDR_W | Address of the oldest unprocessed frame |
| byte_cnt | output | BUF_AW+1 | Bytes held in the buffer, padding included |
| miss_cnt | output | MISS_W | Count of dropped frames |

## Verification
The bench builds the block with BUF_AW=6, which gives a 64-byte ring, and places it at BASE_ADDR=0x0200. A handful of short frames then moves the write pointer around the end of the ring several times. The same small ring makes the exact-fit and one-byte-too-many cases cheap to set up. Frame lengths of 60 and 70 bytes reach the largest acceptable footprint and a footprint that can never fit. An 8-bit miss counter and an 8-bit frame count keep those paths short.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_STAT = 2'd1,
    WR_LEN  = 2'd2,
    WR_DATA = 2'd3
  } wr_state_e;
endpackage

// File: rtl/rxdma_writer.sv
// Frame writer: admission test, header and payload writes, ring write pointer.
module rxdma_writer
  import rxdma_pkg::*;
#(
  parameter int BUF_AW = 12,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sof,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [15:0]       rx_stat,
  input  logic              rx_dvalid,
  input  logic [15:0]       rx_data,
  input  logic [BUF_AW:0]   free_bytes,
  output logic              dma_we,
  output logic [BUF_AW-1:0] dma_off,
  output logic [15:0]       dma_wdata,
  output logic              commit,
  output logic [BUF_AW:0]   commit_bytes,
  output logic              drop
);
  localparam int NEED_W = LEN_W + 2;
  localparam int CMP_W  = (NEED_W > BUF_AW + 1) ? NEED_W : BUF_AW + 1;

  wr_state_e          st_q, st_n;
  logic [BUF_AW-1:0]  wp_q, wp_n;
  logic [LEN_W-1:0]   len_q;
  logic [15:0]        stat_q;
  logic [BUF_AW:0]    need_q;
  logic [LEN_W-1:0]   widx_q, widx_n;
  logic               hdr_en;

  logic [NEED_W-1:0]  need_in;
  logic               fits;
  logic [LEN_W:0]     nw_full;
  logic [LEN_W-1:0]   nwords;
  logic               last_word;

  // R2: footprint = header + payload rounded up to a 4-byte multiple
  assign need_in   = (NEED_W'(rx_len) + NEED_W'(7)) & ~NEED_W'(3);
  // R7: admission against free bytes
  assign fits      = CMP_W'(need_in) <= CMP_W'(free_bytes);
  assign nw_full   = ({1'b0, len_q} + (LEN_W+1)'(1)) >> 1;
  assign nwords    = nw_full[LEN_W-1:0];
  assign last_word = (widx_q == nwords - LEN_W'(1));

  always_comb begin
    st_n         = st_q;
    wp_n         = wp_q;
    widx_n       = widx_q;
    hdr_en       = 1'b0;
    dma_we       = 1'b0;
    dma_off      = wp_q;
    dma_wdata    = stat_q;
    commit       = 1'b0;
    drop         = 1'b0;
    commit_bytes = need_q;
    case (st_q)
      WR_IDLE: begin
        if (rx_sof) begin
          if (fits) begin
            hdr_en = 1'b1;
            st_n   = WR_STAT;
          end else begin
            drop = 1'b1;
          end
        end
      end
      WR_STAT: begin
        // R1: status halfword at the frame start
        dma_we = 1'b1;
        st_n   = WR_LEN;
      end
      WR_LEN: begin
        dma_we    = 1'b1;
        dma_off   = wp_q + BUF_AW'(2);
        dma_wdata = 16'(len_q);
        widx_n    = '0;
        if (nwords == '0) begin
          commit = 1'b1;
          wp_n   = wp_q + need_q[BUF_AW-1:0];
          st_n   = WR_IDLE;
        end else begin
          st_n = WR_DATA;
        end
      end
      WR_DATA: begin
        // R3: offsets wrap modulo the ring size
        dma_off   = wp_q + BUF_AW'(4) + BUF_AW'({widx_q, 1'b0});
        dma_wdata = rx_data;
        if (rx_dvalid) begin
          dma_we = 1'b1;
          widx_n = widx_q + LEN_W'(1);
          if (last_word) begin
            commit = 1'b1;
            wp_n   = wp_q + need_q[BUF_AW-1:0];
            st_n   = WR_IDLE;
          end
        end
      end
      default: st_n = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      wp_q   <= '0;
      widx_q <= '0;
      len_q  <= '0;
      stat_q <= '0;
      need_q <= '0;
    end else begin
      st_q   <= st_n;
      wp_q   <= wp_n;
      widx_q <= widx_n;
      if (hdr_en) begin
        len_q  <= rx_len;
        stat_q <= rx_stat;
        need_q <= need_in[BUF_AW:0];
      end
    end
  end
endmodule

// File: rtl/rxdma_space.sv
// Ring occupancy and oldest-frame offset.
module rxdma_space #(
  parameter int BUF_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [BUF_AW:0]   commit_bytes,
  input  logic              release_en,
  input  logic [BUF_AW:0]   rel_bytes,
  output logic [BUF_AW:0]   used,
  output logic [BUF_AW-1:0] rd_off,
  output logic [BUF_AW:0]   free_bytes
);
  localparam logic [BUF_AW:0] SIZE = {1'b1, {BUF_AW{1'b0}}};

  logic [BUF_AW:0]   used_q, used_n;
  logic [BUF_AW-1:0] rd_q, rd_n;

  always_comb begin
    used_n = used_q;
    rd_n   = rd_q;
    if (commit)     used_n = used_n + commit_bytes;
    if (release_en) begin
      // R5: release frees the reserved footprint and moves the start pointer
      used_n = used_n - rel_bytes;
      rd_n   = rd_q + rel_bytes[BUF_AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      rd_q   <= '0;
    end else begin
      used_q <= used_n;
      rd_q   <= rd_n;
    end
  end

  assign used       = used_q;
  assign rd_off     = rd_q;
  assign free_bytes = SIZE - used_q;
endmodule

// File: rtl/rxdma_count.sv
// Two-phase frame-count handshake: reserve read, then release read.
module rxdma_count #(
  parameter int BUF_AW = 12,
  parameter int CNT_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [BUF_AW:0] commit_bytes,
  input  logic            cnt_rd,
  output logic [CNT_W-1:0] cnt_val,
  output logic            release_en,
  output logic [BUF_AW:0] rel_bytes,
  output logic            phase
);
  logic              ph_q, ph_n;
  logic [CNT_W-1:0]  pc_q, pc_n, rc_q, rc_n;
  logic [BUF_AW:0]   pb_q, pb_n, rb_q, rb_n;
  logic [CNT_W-1:0]  add_c;
  logic [BUF_AW:0]   add_b;

  assign add_c = commit ? CNT_W'(1) : '0;
  assign add_b = commit ? commit_bytes : '0;

  always_comb begin
    ph_n = ph_q;
    pc_n = pc_q + add_c;
    pb_n = pb_q + add_b;
    rc_n = rc_q;
    rb_n = rb_q;
    if (cnt_rd) begin
      // R6: every read flips the phase
      ph_n = ~ph_q;
      if (!ph_q) begin
        // R4: reserve read moves pending frames into the reserved set
        rc_n = pc_q;
        rb_n = pb_q;
        pc_n = add_c;
        pb_n = add_b;
      end else begin
        // R10: frames arriving meanwhile stay pending
        rc_n = '0;
        rb_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      pc_q <= '0;
      pb_q <= '0;
      rc_q <= '0;
      rb_q <= '0;
    end else begin
      ph_q <= ph_n;
      pc_q <= pc_n;
      pb_q <= pb_n;
      rc_q <= rc_n;
      rb_q <= rb_n;
    end
  end

  assign cnt_val    = ph_q ? rc_q : pc_q;
  assign release_en = cnt_rd & ph_q;
  assign rel_bytes  = rb_q;
  assign phase      = ph_q;
endmodule

// File: rtl/rxdma_frame_buf.sv
module rxdma_frame_buf #(
  parameter int               BUF_AW    = 12,
  parameter int               LEN_W     = 16,
  parameter int               CNT_W     = 16,
  parameter int               ADDR_W    = 16,
  parameter int               MISS_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sof,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [15:0]       rx_stat,
  input  logic              rx_dvalid,
  input  logic [15:0]       rx_data,
  output logic              dma_we,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [15:0]       dma_wdata,
  input  logic              cnt_rd,
  output logic [CNT_W-1:0]  cnt_val,
  input  logic              evt_rd,
  output logic [15:0]       buf_evt,
  output logic [ADDR_W-1:0] sof_ptr,
  output logic [BUF_AW:0]   byte_cnt,
  output logic [MISS_W-1:0] miss_cnt
);
  logic [BUF_AW-1:0] dma_off, rd_off;
  logic [BUF_AW:0]   free_bytes, commit_bytes, rel_bytes;
  logic              wr_commit, wr_drop, release_en, cnt_phase;
  logic              evt_q, evt_n;
  logic [MISS_W-1:0] miss_q, miss_n;

  rxdma_writer #(.BUF_AW(BUF_AW), .LEN_W(LEN_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_len(rx_len),
    .rx_stat(rx_stat), .rx_dvalid(rx_dvalid), .rx_data(rx_data),
    .free_bytes(free_bytes), .dma_we(dma_we), .dma_off(dma_off),
    .dma_wdata(dma_wdata), .commit(wr_commit),
    .commit_bytes(commit_bytes), .drop(wr_drop)
  );

  rxdma_space #(.BUF_AW(BUF_AW)) u_space (
    .clk(clk), .rst_n(rst_n), .commit(wr_commit),
    .commit_bytes(commit_bytes), .release_en(release_en),
    .rel_bytes(rel_bytes), .used(byte_cnt), .rd_off(rd_off),
    .free_bytes(free_bytes)
  );

  rxdma_count #(.BUF_AW(BUF_AW), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .commit(wr_commit),
    .commit_bytes(commit_bytes), .cnt_rd(cnt_rd), .cnt_val(cnt_val),
    .release_en(release_en), .rel_bytes(rel_bytes), .phase(cnt_phase)
  );

  // R8: completion sets, read clears, set wins
  assign evt_n  = wr_commit | (evt_q & ~evt_rd);
  // R7: one missed frame per dropped announcement
  assign miss_n = wr_drop ? miss_q + MISS_W'(1) : miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      miss_q <= '0;
    end else begin
      evt_q  <= evt_n;
      miss_q <= miss_n;
    end
  end

  assign dma_addr = BASE_ADDR + ADDR_W'(dma_off);
  assign sof_ptr  = BASE_ADDR + ADDR_W'(rd_off);
  assign buf_evt  = {8'h00, evt_q, 7'h00};
  assign miss_cnt = miss_q;
endmodule

// File: rtl/rxdma_frame_buf_chk.sv
module rxdma_frame_buf_chk #(
  parameter int               BUF_AW    = 12,
  parameter int               ADDR_W    = 16,
  parameter int               MISS_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUF_AW:0]   byte_cnt,
  input logic [ADDR_W-1:0] sof_ptr,
  input logic              dma_we,
  input logic [ADDR_W-1:0] dma_addr,
  input logic              cnt_rd,
  input logic              phase,
  input logic              commit,
  input logic              evt_rd,
  input logic              evt_bit,
  input logic [MISS_W-1:0] miss_cnt,
  input logic [BUF_AW:0]   rel_bytes
);
  localparam logic [BUF_AW:0] SIZE   = {1'b1, {BUF_AW{1'b0}}};
  localparam logic [ADDR_W:0] LO     = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] HI     = LO + (ADDR_W+1)'(SIZE);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= SIZE);

  // R2
  sof_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_ptr[1:0] == BASE_ADDR[1:0]);

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_we |-> ({1'b0, dma_addr} >= LO && {1'b0, dma_addr} < HI));

  // R6
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd |=> phase != $past(phase));

  // R8
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> evt_bit);

  // R8
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !commit) |=> !evt_bit);

  // R5
  release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && phase && !commit) |=> byte_cnt == $past(byte_cnt) - $past(rel_bytes));

  // R7
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_cnt == $past(miss_cnt) || miss_cnt == $past(miss_cnt) + MISS_W'(1)));
endmodule

bind rxdma_frame_buf rxdma_frame_buf_chk #(
  .BUF_AW(BUF_AW), .ADDR_W(ADDR_W), .MISS_W(MISS_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_cnt(byte_cnt), .sof_ptr(sof_ptr),
  .dma_we(dma_we), .dma_addr(dma_addr), .cnt_rd(cnt_rd), .phase(cnt_phase),
  .commit(wr_commit), .evt_rd(evt_rd), .evt_bit(buf_evt[7]),
  .miss_cnt(miss_cnt), .rel_bytes(rel_bytes)
);

// File: tb/tb_rxdma_frame_buf.sv
module tb_rxdma_frame_buf;
  localparam int BUF_AW = 6;
  localparam int SIZE   = 1 << BUF_AW;
  localparam int LEN_W  = 16;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 16;
  localparam int MISS_W = 8;
  localparam logic [15:0] BASE = 16'h0200;

  logic clk, rst_n;
  logic rx_sof, rx_dvalid, cnt_rd, evt_rd;
  logic [LEN_W-1:0] rx_len;
  logic [15:0] rx_stat, rx_data;
  logic dma_we;
  logic [ADDR_W-1:0] dma_addr, sof_ptr;
  logic [15:0] dma_wdata, buf_evt;
  logic [CNT_W-1:0] cnt_val;
  logic [BUF_AW:0] byte_cnt;
  logic [MISS_W-1:0] miss_cnt;

  rxdma_frame_buf #(.BUF_AW(BUF_AW), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .MISS_W(MISS_W), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_len(rx_len),
    .rx_stat(rx_stat), .rx_dvalid(rx_dvalid), .rx_data(rx_data),
    .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .cnt_rd(cnt_rd), .cnt_val(cnt_val), .evt_rd(evt_rd), .buf_evt(buf_evt),
    .sof_ptr(sof_ptr), .byte_cnt(byte_cnt), .miss_cnt(miss_cnt));

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int nchk = 0, nfail = 0;
  bit done = 0;

  // bench model
  int m_used = 0, m_rd = 0, m_wp = 0, m_pc = 0, m_pb = 0, m_rc = 0, m_rb = 0;
  int m_ph = 0, m_miss = 0, m_evt = 0;

  // write capture, sampled mid-cycle
  int cap_n = 0;
  logic [15:0] cap_a [0:63];
  logic [15:0] cap_d [0:63];
  always begin
    @(negedge clk); #2;
    if (rst_n && dma_we && cap_n < 64) begin
      cap_a[cap_n] = dma_addr;
      cap_d[cap_n] = dma_wdata;
      cap_n++;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int need_of(int len);
    return ((len + 7) / 4) * 4;
  endfunction

  function automatic logic [15:0] word_of(logic [15:0] st, int k);
    return 16'(st + k * 37 + 16'h0a00);
  endfunction

  task automatic check_all();
    chk("R5 byte_cnt", int'(byte_cnt), m_used);
    chk("R5 sof_ptr", int'(sof_ptr), int'(BASE) + m_rd);
    chk("R4 cnt_val", int'(cnt_val), m_ph ? m_rc : m_pc);
    chk("R7 miss_cnt", int'(miss_cnt), m_miss % 256);
    chk("R8 buf_evt", int'(buf_evt), m_evt ? 16'h0080 : 0);
  endtask

  task automatic send_frame(int len, logic [15:0] st, bit gaps);
    int need, nw;
    bit fits;
    need = need_of(len);
    nw   = (len + 1) / 2;
    fits = need <= SIZE - m_used;
    @(negedge clk);
    cap_n = 0;
    rx_sof = 1'b1; rx_len = LEN_W'(len); rx_stat = st;
    @(negedge clk);
    rx_sof = 1'b0;
    @(negedge clk);
    for (int k = 0; k < nw; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        rx_dvalid = 1'b0;
      end
      @(negedge clk);
      rx_dvalid = 1'b1;
      rx_data   = word_of(st, k);
    end
    @(negedge clk);
    rx_dvalid = 1'b0;
    #3;
    if (fits) begin
      // R1 layout, R3 wrapped addresses
      chk("R1 write count", cap_n, 2 + nw);
      if (cap_n == 2 + nw) begin
        chk("R1 status addr", int'(cap_a[0]), int'(BASE) + m_wp);
        chk("R1 status data", int'(cap_d[0]), int'(st));
        chk("R1 length addr", int'(cap_a[1]), int'(BASE) + (m_wp + 2) % SIZE);
        chk("R1 length data", int'(cap_d[1]), len);
        for (int k = 0; k < nw; k++) begin
          chk("R3 payload addr", int'(cap_a[2+k]), int'(BASE) + (m_wp + 4 + 2*k) % SIZE);
          chk("R1 payload data", int'(cap_d[2+k]), int'(word_of(st, k)));
        end
      end
      m_wp = (m_wp + need) % SIZE;   // R2
      m_used += need;
      m_pc++; m_pb += need;
      m_evt = 1;
    end else begin
      chk("R7 dropped frame writes", cap_n, 0);
      m_miss++;
    end
    check_all();
  endtask

  task automatic rd_count();
    @(negedge clk);
    cnt_rd = 1'b1;
    #2;
    if (m_ph == 0) chk("R4 reserve read", int'(cnt_val), m_pc);
    else           chk("R5 release read", int'(cnt_val), m_rc);
    @(negedge clk);
    cnt_rd = 1'b0;
    if (m_ph == 0) begin
      m_rc = m_pc; m_rb = m_pb; m_pc = 0; m_pb = 0;
    end else begin
      m_used -= m_rb; m_rd = (m_rd + m_rb) % SIZE; m_rc = 0; m_rb = 0;
    end
    m_ph ^= 1;   // R6
    #3;
    check_all();
  endtask

  task automatic rd_evt();
    @(negedge clk);
    evt_rd = 1'b1;
    #2;
    chk("R8 event bit", int'(buf_evt[7]), m_evt);
    @(negedge clk);
    evt_rd = 1'b0;
    m_evt = 0;
    #3;
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; rx_sof = 0; rx_dvalid = 0; cnt_rd = 0; evt_rd = 0;
    rx_len = '0; rx_stat = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R9 reset state
    chk("R9 sof_ptr at base", int'(sof_ptr), int'(BASE));
    check_all();

    // R1 odd length, zero length
    send_frame(5, 16'h1234, 0);
    send_frame(0, 16'h00c1, 0);
    rd_evt();
    // R4 reserve, R10 frame after reservation, R5 release
    rd_count();
    send_frame(6, 16'h0222, 1);
    rd_count();
    rd_count();
    rd_count();
    // R7 exact fit then overflow by one byte
    send_frame(10, 16'h0333, 0);
    send_frame(SIZE - m_used - 4, 16'h0444, 1);
    chk("R7 buffer full", int'(byte_cnt), SIZE);
    send_frame(1, 16'h0555, 0);
    rd_count();
    rd_count();
    send_frame(70, 16'h0666, 0);
    send_frame(60, 16'h0777, 0);
    rd_count();
    rd_count();

    // constrained random mix
    for (int i = 0; i < 200; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 5) begin
        int len;
        len = $urandom % 31;
        if ($urandom % 12 == 0) len = 60 + ($urandom % 12);
        send_frame(len, 16'($urandom), bit'($urandom % 2));
      end else if (r < 8) begin
        rd_count();
      end else begin
        rd_evt();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule